// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns one host access into the pin sequence of a NAND flash bus. An access is a command, an address or a data transfer. The host gives a bank number, a read or write flag and one write byte. The block drives four active-low chip enables, the command and address latch enables, the active-low read and write strobes, and an 8-bit data bus with its own output enable. A read returns the captured byte, and every access ends with a one-cycle done pulse.

The timing comes from six configuration fields, which are copied when a request is accepted. The setup phase runs before the strobe. The strobe phase can be stretched while the active-low wait input is low. The hold phase runs after the strobe. A write keeps the bus in high impedance for a set time after the access starts. A read waits a latch-to-read gap before its read strobe. The block handles one access at a time. A ready output tells the host when the next request can be issued.

Top module: `nand_timing_seq`

## Requirements
- R1: While reset is asserted, ready_o is 1 and done_o is 0. All four ce_no bits are 1, cle_o and ale_o are 0, re_no and we_no are 1, and dq_oe_o is 0.
- R2: A request is taken on a clock edge where req_valid_i and ready_o are both 1. ready_o then stays 0 until the cycle in which done_o is 1. done_o is 1 for exactly that one cycle, in which ready_o is already 1 again. Requests presented while ready_o is 0 have no effect.
- R3: req_kind_i encodes the access kind: 2'b00 is a command, 2'b01 is an address, and 2'b10 or 2'b11 is data. For the whole access, cle_o is 1 only for a command and ale_o is 1 only for an address. Command and address accesses always pulse we_no, whatever req_write_i says. A data access with req_write_i equal to 0 is a read and pulses re_no.
- R4: Throughout an access, only ce_no[bank] is 0, where bank is the req_bank_i value at acceptance. Bank 0 is reached by the value 0.
- R5: The first strobe cycle (we_no or re_no at 0) comes cfg_setup_i+1 cycles after the first cycle of the access. For a read, the gap cycles of R10 are added to this.
- R6: With wait_ni held high, the strobe stays at 0 for cfg_wait_i+1 cycles.
- R7: Each clock edge in the strobe phase at which wait_ni is 0 adds one strobe cycle. The strobe count stays frozen during those edges.
- R8: After the strobe returns to 1, the bank enable and the latch enable stay active for cfg_hold_i+1 cycles. done_o follows in the next cycle.
- R9: On writes, dq_oe_o is 0 for the first cfg_hiz_i cycles of the access and then 1 until the access ends. dq_o carries the accepted req_wdata_i while dq_oe_o is 1.
- R10: A read inserts a gap of G+1 cycles between setup and the read strobe. G is bits [3:0] of cfg_cle_re_i if the most recent command or address access was a command, or if there has been none since reset. Otherwise G is bits [3:0] of cfg_ale_re_i. Bits [7:4] of both fields are ignored. dq_oe_o stays 0 throughout a read.
- R11: A read captures dq_i at the clock edge that ends the last cycle with re_no at 0. The captured byte is on rdata_o when done_o is 1.
- R12: All timing fields are copied at acceptance. Changing the configuration inputs during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | Access kind: 00 command, 01 address, 1x data |
| req_write_i | input | 1 | 1 for a write data access |
| req_wdata_i | input | 8 | Byte to drive on writes |
| req_bank_i | input | 2 | Target bank |
| cfg_setup_i | input | 8 | Setup length minus one |
| cfg_wait_i | input | 8 | Strobe length minus one |
| cfg_hold_i | input | 8 | Hold length minus one |
| cfg_hiz_i | input | 8 | Write bus turnaround cycles |
| cfg_cle_re_i | input | 8 | Command-to-read gap minus one, low 4 bits used |
| cfg_ale_re_i | input | 8 | Address-to-read gap minus one, low 4 bits used |
| wait_ni | input | 1 | Strobe extension request, active low |
| dq_i | input | 8 | Data bus input from flash |
| ready_o | output | 1 | Idle, can accept a request |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rdata_o | output | 8 | Last read byte |
| ce_no | output | 4 | Bank chip enables, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| re_no | output | 1 | Read strobe, active low |
| we_no | output | 1 | Write strobe, active low |
| dq_o | output | 8 | Data bus output |
| dq_oe_o | output | 1 | Data bus output enable |

## Verification
A wrong phase or a wrong counter value shows at the ports as a strobe edge in the wrong cycle. It can also show as a wrong strobe width or a wrong done time, and all of these appear within the access in which the fault happens. A wrong latched bank, kind or direction shows in the first cycle after acceptance, as a wrong chip enable, latch enable or strobe. A wrong record of the last latch kind only shows in the next read, as a wrong gap before the read strobe. A high-impedance counter that is off by one moves the first output-enable cycle by one cycle. A capture one cycle early or late returns a byte that differs from the expected one, because the bench changes dq_i every cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_GAP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  localparam logic [1:0] KIND_CMD  = 2'b00;
  localparam logic [1:0] KIND_ADDR = 2'b01;
endpackage

// File: rtl/nand_rd_gap_sel.sv
module nand_rd_gap_sel #(
  parameter int TIME_W = 8,
  parameter int GAP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [1:0]        kind_i,
  input  logic [TIME_W-1:0] cfg_cle_re_i,
  input  logic [TIME_W-1:0] cfg_ale_re_i,
  output logic [GAP_W-1:0]  gap_o
);
  import nand_seq_pkg::*;

  logic last_cmd_q;
  logic unused_hi;

  // tracks which latch enable was used most recently
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_cmd_q <= 1'b1;
    end else if (accept_i && kind_i == KIND_CMD) begin
      last_cmd_q <= 1'b1;
    end else if (accept_i && kind_i == KIND_ADDR) begin
      last_cmd_q <= 1'b0;
    end
  end

  assign gap_o = last_cmd_q ? cfg_cle_re_i[GAP_W-1:0] : cfg_ale_re_i[GAP_W-1:0];
  assign unused_hi = ^{cfg_cle_re_i[TIME_W-1:GAP_W], cfg_ale_re_i[TIME_W-1:GAP_W]};
endmodule

// File: rtl/nand_hiz_gate.sv
module nand_hiz_gate #(
  parameter int TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic [TIME_W-1:0] hiz_i,
  output logic              open_o
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (accept_i) begin
      cnt_q <= hiz_i;
    end else if (busy_i && cnt_q != '0) begin
      cnt_q <= cnt_q - TIME_W'(1);
    end
  end

  assign open_o = (cnt_q == '0);

  // R9
  hiz_count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !accept_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TIME_W'(1)));
endmodule

// File: rtl/nand_phase_ctrl.sv
module nand_phase_ctrl #(
  parameter int TIME_W = 8,
  parameter int GAP_W  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 accept_i,
  input  logic                 is_read_i,
  input  logic                 wait_ni,
  input  logic [TIME_W-1:0]    setup_i,
  input  logic [TIME_W-1:0]    wait_i,
  input  logic [TIME_W-1:0]    hold_i,
  input  logic [GAP_W-1:0]     gap_i,
  output nand_seq_pkg::phase_e phase_o,
  output logic                 rd_o,
  output logic                 capture_o,
  output logic                 done_o
);
  import nand_seq_pkg::*;

  phase_e            phase_q;
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] wait_q;
  logic [TIME_W-1:0] hold_q;
  logic [GAP_W-1:0]  gap_q;
  logic              rd_q;
  logic              done_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
      gap_q   <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept_i) begin
            phase_q <= PH_SETUP;
            cnt_q   <= setup_i;
            wait_q  <= wait_i;
            hold_q  <= hold_i;
            gap_q   <= gap_i;
            rd_q    <= is_read_i;
          end
        end
        PH_SETUP: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - TIME_W'(1);
          end else if (rd_q) begin
            phase_q <= PH_GAP;
            cnt_q   <= TIME_W'(gap_q);
          end else begin
            phase_q <= PH_STROBE;
            cnt_q   <= wait_q;
          end
        end
        PH_GAP: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - TIME_W'(1);
          end else begin
            phase_q <= PH_STROBE;
            cnt_q   <= wait_q;
          end
        end
        PH_STROBE: begin
          // wait_ni low freezes the phase
          if (wait_ni) begin
            if (!cnt_zero) begin
              cnt_q <= cnt_q - TIME_W'(1);
            end else begin
              phase_q <= PH_HOLD;
              cnt_q   <= hold_q;
            end
          end
        end
        PH_HOLD: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - TIME_W'(1);
          end else begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign rd_o      = rd_q;
  assign done_o    = done_q;
  assign capture_o = (phase_q == PH_STROBE) && cnt_zero && wait_ni && rd_q;

  // R7
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && !wait_ni) |=> (phase_q == PH_STROBE && $stable(cnt_q)));

  // R2
  done_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_IDLE && $past(phase_q) == PH_HOLD));

  // R10
  gap_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP) |-> rd_q);

  // R8
  hold_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && $past(phase_q) != PH_HOLD) |-> ($past(phase_q) == PH_STROBE));
endmodule

// File: rtl/nand_timing_seq.sv
module nand_timing_seq #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 8,
  parameter int TIME_W    = 8,
  parameter int GAP_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [TIME_W-1:0] cfg_setup_i,
  input  logic [TIME_W-1:0] cfg_wait_i,
  input  logic [TIME_W-1:0] cfg_hold_i,
  input  logic [TIME_W-1:0] cfg_hiz_i,
  input  logic [TIME_W-1:0] cfg_cle_re_i,
  input  logic [TIME_W-1:0] cfg_ale_re_i,
  input  logic              wait_ni,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_BANKS-1:0] ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              re_no,
  output logic              we_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  import nand_seq_pkg::*;

  phase_e            phase;
  logic              busy;
  logic              accept;
  logic              is_read;
  logic              rd;
  logic              capture;
  logic              hiz_open;
  logic [GAP_W-1:0]  gap;
  logic [1:0]        kind_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  assign busy    = (phase != PH_IDLE);
  assign accept  = req_valid_i && !busy;
  assign is_read = req_kind_i[1] && !req_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= req_kind_i;
      bank_q  <= req_bank_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= dq_i;
    end
  end

  nand_rd_gap_sel #(.TIME_W(TIME_W), .GAP_W(GAP_W)) u_gap_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .kind_i      (req_kind_i),
    .cfg_cle_re_i(cfg_cle_re_i),
    .cfg_ale_re_i(cfg_ale_re_i),
    .gap_o       (gap)
  );

  nand_phase_ctrl #(.TIME_W(TIME_W), .GAP_W(GAP_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .is_read_i(is_read),
    .wait_ni  (wait_ni),
    .setup_i  (cfg_setup_i),
    .wait_i   (cfg_wait_i),
    .hold_i   (cfg_hold_i),
    .gap_i    (gap),
    .phase_o  (phase),
    .rd_o     (rd),
    .capture_o(capture),
    .done_o   (done_o)
  );

  nand_hiz_gate #(.TIME_W(TIME_W)) u_hiz (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .busy_i  (busy),
    .hiz_i   (cfg_hiz_i),
    .open_o  (hiz_open)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ce
    assign ce_no[b] = !(busy && bank_q == BANK_W'(b));
  end

  assign ready_o = !busy;
  assign cle_o   = busy && kind_q == KIND_CMD;
  assign ale_o   = busy && kind_q == KIND_ADDR;
  assign we_no   = !(phase == PH_STROBE && !rd);
  assign re_no   = !(phase == PH_STROBE && rd);
  assign dq_oe_o = busy && !rd && hiz_open;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

  // R4
  ce_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (&ce_no));

  // R4
  ce_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> ($countones(~ce_no) == 1));

  // R3
  latch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!re_no && !we_no));

  // R10
  oe_not_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (re_no && !ready_o));

  // R12
  bank_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !$past(ready_o)) |-> $stable(ce_no));
endmodule

// File: tb/nand_timing_seq_tb.sv
module nand_timing_seq_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic [1:0] req_bank = '0;
  logic [7:0] cfg_setup = '0, cfg_wait = '0, cfg_hold = '0, cfg_hiz = '0;
  logic [7:0] cfg_clr = '0, cfg_alr = '0;
  logic       wait_n = 1'b1;
  logic [7:0] dq_in = '0;
  logic       ready, done, cle, ale, re_n, we_n, dq_oe;
  logic [7:0] rdata, dq_out;
  logic [3:0] ce_n;

  int checks = 0;
  int errors = 0;
  int last_cmd = 1;

  always #2 clk = ~clk;

  nand_timing_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_write_i(req_write), .req_wdata_i(req_wdata), .req_bank_i(req_bank),
    .cfg_setup_i(cfg_setup), .cfg_wait_i(cfg_wait), .cfg_hold_i(cfg_hold),
    .cfg_hiz_i(cfg_hiz), .cfg_cle_re_i(cfg_clr), .cfg_ale_re_i(cfg_alr),
    .wait_ni(wait_n), .dq_i(dq_in), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .ce_no(ce_n), .cle_o(cle), .ale_o(ale), .re_no(re_n),
    .we_no(we_n), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_access(input int kind, input int wr, input int wd, input int bank,
                            input int s, input int w, input int h, input int z,
                            input int cl, input int al, input int stall, input int pat);
    int rd, gap, ts_exp, len_exp, done_exp, oe_exp, ts, len, tdone, oe_first, oe_cnt;
    int k, bad_ctl, bad_dq, rd_val;
    rd = (kind >= 2 && wr == 0) ? 1 : 0;
    gap = rd ? ((last_cmd ? cl : al) & 15) + 1 : 0;
    ts_exp = s + 1 + gap;
    len_exp = w + 1 + stall;
    done_exp = ts_exp + len_exp + h + 1;
    oe_exp = (!rd && z < done_exp) ? done_exp - z : 0;
    ts = -1; len = 0; tdone = -1; oe_first = -1; oe_cnt = 0; bad_ctl = 0; bad_dq = 0; rd_val = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_write = wr[0]; req_wdata = 8'(wd);
    req_bank = 2'(bank);
    cfg_setup = 8'(s); cfg_wait = 8'(w); cfg_hold = 8'(h); cfg_hiz = 8'(z);
    cfg_clr = 8'(cl); cfg_alr = 8'(al);
    @(posedge clk);
    k = 0;
    while (k < 4000 && tdone < 0) begin
      @(negedge clk);
      if (done) begin
        tdone = k;
        req_valid = 1'b0;
        if (rd) rd_val = int'(rdata);
      end else begin
        if (ready) bad_ctl++;
        if (ce_n != ~(4'b0001 << bank)) bad_ctl++;
        if (cle != (kind == 0) || ale != (kind == 1)) bad_ctl++;
        if (rd ? !we_n : !re_n) bad_ctl++;
        if (rd ? !re_n : !we_n) begin
          if (ts < 0) ts = k;
          len++;
        end
        if (dq_oe) begin
          if (oe_first < 0) oe_first = k;
          oe_cnt++;
          if (dq_out != 8'(wd)) bad_dq++;
        end
        // R12, R2: disturb config and offer a foreign request while busy
        cfg_setup = 8'hFF; cfg_wait = 8'hFF; cfg_hold = 8'hFF; cfg_hiz = 8'h00;
        cfg_clr = 8'h0F; cfg_alr = 8'h0F;
        req_bank = 2'(bank + 1); req_kind = 2'(kind ^ 1); req_write = ~wr[0];
        wait_n = (k >= ts_exp && k < ts_exp + stall) ? 1'b0 : 1'b1;
        dq_in = 8'(pat ^ k);
      end
      k++;
    end
    wait_n = 1'b1;
    chk(ts == ts_exp, rd ? "R5 R10 strobe start" : "R5 strobe start", ts, ts_exp);
    chk(len == len_exp, stall > 0 ? "R7 stretched strobe" : "R6 strobe width", len, len_exp);
    chk(tdone == done_exp, "R8 done time", tdone, done_exp);
    chk(bad_ctl == 0, "R3 R4 R2 control lines", bad_ctl, 0);
    chk(oe_cnt == oe_exp, rd ? "R10 no oe on read" : "R9 oe cycles", oe_cnt, oe_exp);
    if (!rd && oe_exp > 0) chk(oe_first == z, "R9 oe start", oe_first, z);
    if (!rd) chk(bad_dq == 0, "R9 dq value", bad_dq, 0);
    if (rd) chk(rd_val == ((pat ^ (ts_exp + len_exp - 1)) & 255), "R11 read capture",
                rd_val, (pat ^ (ts_exp + len_exp - 1)) & 255);
    @(negedge clk);
    chk(!done && ready && ce_n == 4'hF, "R2 single done, busy request ignored",
        int'({done, ready, ce_n}), 32'h1F);
    if (kind == 0) last_cmd = 1;
    if (kind == 1) last_cmd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(ready && !done && ce_n == 4'hF && !cle && !ale && re_n && we_n && !dq_oe,
        "R1 reset state", int'({ready, done, ce_n, cle, ale, re_n, we_n, dq_oe}), 11'h5E6);
    rst_ni = 1'b1;
    @(negedge clk);
    // first read after reset uses the command gap (R10)
    run_access(2, 0, 0, 0, 0, 0, 0, 0, 8'hF2, 8'h35, 0, 8'h5A);
    for (int it = 0; it < 64; it++) begin
      run_access(it % 4, (it / 4) % 2, (it * 37 + 11) & 255, (it / 7) % 4,
                 (it % 3 == 2) ? 3 : it % 3, (it / 3) % 3, (it / 5) % 3, (it / 2) % 4,
                 8'hF0 | (it % 5), 8'h30 | ((it * 3) % 7), (it % 4 == 1) ? 2 : 0,
                 (it * 29) & 255);
    end
    // boundary values: full 8-bit timings, 16-cycle gaps with upper bits set
    run_access(0, 1, 8'h70, 3, 255, 0, 0, 255, 8'hFF, 8'hFF, 0, 0);
    run_access(3, 0, 0, 2, 255, 255, 255, 0, 8'hFF, 8'h10, 3, 8'hC3);
    run_access(1, 0, 8'h11, 1, 0, 0, 0, 0, 8'h10, 8'hFF, 0, 0);
    run_access(2, 0, 0, 0, 1, 1, 1, 0, 8'h10, 8'hFF, 1, 8'h3C);
    run_access(2, 1, 8'hA5, 0, 0, 0, 255, 1, 8'h10, 8'h10, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule